// File: doc/BRIEF.md
# Decade Divider Counter with Split Sections

This block is a four-bit counter made of two sections that each have their own count input. The low section divides by two and drives `count[0]`. The high section divides by five on `count[3:1]`, stepping through the binary values 0 to 4 and then wrapping to 0. Both count inputs are active on their falling edge. Each is synchronised to the system clock and turned into a one-cycle advance event.

A two-bit chain mode sets how the sections are wired together:

- **Split:** the sections run independently.
- **Decimal:** the low section drives the high section, so the counter follows plain 8421 BCD from 0 to 9.
- **Bi-quinary:** the high section drives the low section, so `count[0]` becomes a symmetrical divide-by-ten square wave.

Two override pairs act without waiting for the clock. Each pair is AND-gated, so both of its inputs must be high. The clear pair empties the counter. The preset pair forces it to nine, and preset wins over clear.

Top module: `decade_div_counter`

## Requirements
- R1: In split mode (`chainMode` = 00), `count[0]` toggles once for each high-to-low transition of `halfTickN`, three system-clock edges after the transition; a low-to-high transition leaves it unchanged.
- R2: In split mode, each high-to-low transition of `quintTickN` steps `count[3:1]` through 0,1,2,3,4 and back to 0, with no value above 4 ever reached.
- R3: With both `clrReqA` and `clrReqB` high and the preset pair not both high, `count` reads 0 without waiting for a clock edge, and stays 0 while any count input toggles.
- R4: A single high clear input, with the other low, has no effect on `count`.
- R5: With both `nineReqA` and `nineReqB` high, `count` reads 9 (binary 1001) without waiting for a clock edge, even while both clear inputs are high.
- R6: A single high preset input, with the other low, has no effect on `count`.
- R7: In decimal mode (`chainMode` = 01), falling edges of `halfTickN` advance `count` through 0..9 and back to 0. Each fall of `count[0]` from 1 to 0 advances the high section one cycle later. `quintTickN` is ignored.
- R8: In bi-quinary mode (`chainMode` = 10), falling edges of `quintTickN` produce the sequence 2,4,6,8,1,3,5,7,9,0. Each fall of `count[3]` from 1 to 0 toggles the low section one cycle later. `halfTickN` is ignored.
- R9: Mode 11 behaves as split mode. In split mode, a wrap of either section never advances the other.
- R10: While `rst_n` is low, `count` reads 0 and the input synchronisers are emptied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous system reset |
| halfTickN | input | 1 | Count input of the divide-by-two section, falling-edge active |
| quintTickN | input | 1 | Count input of the divide-by-five section, falling-edge active |
| clrReqA | input | 1 | Clear request, first input of the AND pair |
| clrReqB | input | 1 | Clear request, second input of the AND pair |
| nineReqA | input | 1 | Preset-to-nine request, first input of the AND pair |
| nineReqB | input | 1 | Preset-to-nine request, second input of the AND pair |
| chainMode | input | 2 | 00 split, 01 decimal, 10 bi-quinary, 11 split |
| count | output | 4 | Counter value: bit 0 is the divide-by-two section, bits 3:1 the divide-by-five section |

## Verification
The preset and the clear can be active together. A count event can also arrive while either override is held. The bench raises both clear inputs, then raises the preset pair on top of them and expects nine. It then drops only the preset and expects the counter to fall to zero by the next clock edge. Count pulses are also driven while the clear pair is held, and the bench checks that the counter stays at zero and resumes from the override value once the pair is released.

// File: rtl/decdiv_pkg.sv
package decdiv_pkg;
  localparam int unsigned QUINT_MOD  = 5;
  localparam int unsigned QUINT_W    = $clog2(QUINT_MOD);
  localparam int unsigned COUNT_W    = QUINT_W + 1;
  localparam int unsigned PRESET_VAL = 9;
  localparam int unsigned LANES      = 2;   // lane 0: half section, lane 1: quint section

  typedef enum logic [1:0] {
    MODE_SPLIT = 2'd0,
    MODE_BCD   = 2'd1,
    MODE_BIQ   = 2'd2,
    MODE_ALT   = 2'd3
  } chain_mode_e;

  typedef struct packed {
    logic advHalf;
    logic advQuint;
  } adv_strobe_t;
endpackage

// File: rtl/decdiv_fall_detect.sv
module decdiv_fall_detect #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic fall
);
  // pipe[STAGES-1:0] synchronise, pipe[STAGES] holds the previous sample
  logic [STAGES:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[STAGES-1:0], din};
  end

  assign fall = pipe[STAGES] & ~pipe[STAGES-1];
endmodule

// File: rtl/decdiv_ctrl.sv
module decdiv_ctrl
  import decdiv_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ovrHit,
  input  logic        halfTickN,
  input  logic        quintTickN,
  input  chain_mode_e mode,
  input  logic        halfWrap,
  input  logic        quintWrap,
  output adv_strobe_t stb
);
  logic [LANES-1:0] laneIn;
  logic [LANES-1:0] laneFall;
  logic carryHalf, carryQuint;

  assign laneIn = {quintTickN, halfTickN};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    decdiv_fall_detect #(.STAGES(SYNC_STAGES)) u_fall (
      .clk (clk),
      .rst_n(rst_n),
      .din (laneIn[g]),
      .fall(laneFall[g])
    );
  end

  always_ff @(posedge clk or posedge ovrHit) begin
    if (ovrHit) begin
      carryHalf  <= 1'b0;
      carryQuint <= 1'b0;
    end else begin
      carryQuint <= (mode == MODE_BCD) && halfWrap;
      carryHalf  <= (mode == MODE_BIQ) && quintWrap;
    end
  end

  always_comb begin
    stb.advHalf  = (mode == MODE_BIQ) ? carryHalf  : laneFall[0];
    stb.advQuint = (mode == MODE_BCD) ? carryQuint : laneFall[1];
  end

  // R7
  bcd_chain_chk: assert property (@(posedge clk) disable iff (!rst_n || ovrHit)
    (mode == MODE_BCD && halfWrap) |=> (stb.advQuint || mode != MODE_BCD));
  // R8
  biq_chain_chk: assert property (@(posedge clk) disable iff (!rst_n || ovrHit)
    (mode == MODE_BIQ && quintWrap) |=> (stb.advHalf || mode != MODE_BIQ));
endmodule

// File: rtl/decdiv_path.sv
module decdiv_path
  import decdiv_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clrHit,
  input  logic               setHit,
  input  adv_strobe_t        stb,
  output logic               half,
  output logic [QUINT_W-1:0] quint,
  output logic               halfWrap,
  output logic               quintWrap
);
  localparam logic [COUNT_W-1:0] PRESET = COUNT_W'(PRESET_VAL);
  localparam logic [QUINT_W-1:0] QLAST  = QUINT_W'(QUINT_MOD - 1);
  localparam logic [QUINT_W-1:0] QMSB   = QUINT_W'(1 << (QUINT_W - 1));

  always_ff @(posedge clk or posedge clrHit or posedge setHit) begin
    if (setHit) begin
      half  <= PRESET[0];
      quint <= PRESET[COUNT_W-1:1];
    end else if (clrHit) begin
      half  <= 1'b0;
      quint <= '0;
    end else begin
      if (stb.advHalf)  half  <= ~half;
      if (stb.advQuint) quint <= (quint == QLAST) ? '0 : quint + 1'b1;
    end
  end

  // a section output falls from 1 to 0 on this advance
  assign halfWrap  = stb.advHalf && half;
  assign quintWrap = stb.advQuint && ((quint & QMSB) != '0);

  // R2
  quint_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    quint <= QLAST);
  // R1
  half_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || clrHit || setHit)
    !stb.advHalf |=> $stable(half));
  // R1
  half_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n || clrHit || setHit)
    stb.advHalf |=> half != $past(half));
  // R5
  preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    setHit |-> ({quint, half} == PRESET));
  // R3
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clrHit && !setHit && $past(clrHit && !setHit)) |-> (half == 1'b0 && quint == '0));
endmodule

// File: rtl/decade_div_counter.sv
module decade_div_counter
  import decdiv_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       halfTickN,
  input  logic       quintTickN,
  input  logic       clrReqA,
  input  logic       clrReqB,
  input  logic       nineReqA,
  input  logic       nineReqB,
  input  logic [1:0] chainMode,
  output logic [3:0] count
);
  logic               clrHit, setHit, ovrHit;
  logic               half, halfWrap, quintWrap;
  logic [QUINT_W-1:0] quint;
  adv_strobe_t        stb;
  chain_mode_e        mode;

  assign clrHit = ~rst_n | (clrReqA & clrReqB);
  assign setHit = nineReqA & nineReqB;
  assign ovrHit = clrHit | setHit;
  assign mode   = chain_mode_e'(chainMode);

  decdiv_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ovrHit    (ovrHit),
    .halfTickN (halfTickN),
    .quintTickN(quintTickN),
    .mode      (mode),
    .halfWrap  (halfWrap),
    .quintWrap (quintWrap),
    .stb       (stb)
  );

  decdiv_path u_path (
    .clk      (clk),
    .rst_n    (rst_n),
    .clrHit   (clrHit),
    .setHit   (setHit),
    .stb      (stb),
    .half     (half),
    .quint    (quint),
    .halfWrap (halfWrap),
    .quintWrap(quintWrap)
  );

  assign count = {quint, half};
endmodule

// File: tb/tb_decade_div_counter.sv
module tb_decade_div_counter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       halfTickN = 1'b1, quintTickN = 1'b1;
  logic       clrReqA = 1'b0, clrReqB = 1'b0, nineReqA = 1'b0, nineReqB = 1'b0;
  logic [1:0] chainMode = 2'b00;
  logic [3:0] count;
  int         nRun = 0, nFail = 0;

  always #4 clk = ~clk;

  decade_div_counter dut (
    .clk(clk), .rst_n(rst_n), .halfTickN(halfTickN), .quintTickN(quintTickN),
    .clrReqA(clrReqA), .clrReqB(clrReqB), .nineReqA(nineReqA), .nineReqB(nineReqB),
    .chainMode(chainMode), .count(count)
  );

  // row: {mode[1:0], pulse[1:0] (10 = halfTickN, 01 = quintTickN), expected[3:0]}
  localparam int NV = 32;
  localparam logic [7:0] VEC [NV] = '{
    8'h61, 8'h62, 8'h63, 8'h64, 8'h65, 8'h66, 8'h67, 8'h68, 8'h69, 8'h60,
    8'h50,
    8'h12, 8'h23, 8'h15, 8'h17, 8'h19, 8'h11, 8'h20,
    8'h92, 8'h94, 8'h96, 8'h98, 8'h91, 8'h93, 8'h95, 8'h97, 8'h99, 8'h90,
    8'hA0,
    8'hE1, 8'hD3, 8'hE2
  };

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: count=%0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse(input logic onHalf);
    if (onHalf) halfTickN = 1'b0; else quintTickN = 1'b0;
    repeat (6) @(negedge clk);
    halfTickN = 1'b1;
    quintTickN = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL R10 watchdog: run still active, expected completion");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset held", count, 4'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 after reset", count, 4'd0);

    for (int i = 0; i < NV; i++) begin
      logic [7:0] row;
      string tag;
      row = VEC[i];
      chainMode = row[7:6];
      @(negedge clk);
      pulse(row[5]);
      tag = (row[7:6] == 2'b01) ? "R7" : (row[7:6] == 2'b10) ? "R8" : "R9";
      check(tag, count, row[3:0]);
    end

    // R1: toggles on fall, rising edge changes nothing (count 2 -> 3)
    chainMode = 2'b00;
    halfTickN = 1'b0;
    repeat (6) @(negedge clk);
    check("R1 falling edge", count, 4'd3);
    halfTickN = 1'b1;
    repeat (6) @(negedge clk);
    check("R1 rising edge ignored", count, 4'd3);

    // R2: five quint pulses bring the high section back to where it began
    for (int k = 0; k < 5; k++) pulse(1'b0);
    check("R2 quint full cycle", count, 4'd3);

    // R4: single clear input
    clrReqA = 1'b1;
    repeat (3) @(negedge clk);
    check("R4 clrReqA alone", count, 4'd3);
    clrReqA = 1'b0; clrReqB = 1'b1;
    repeat (3) @(negedge clk);
    check("R4 clrReqB alone", count, 4'd3);

    // R3: clear pair acts before the next clock edge
    clrReqA = 1'b1;
    #1;
    check("R3 async clear", count, 4'd0);
    @(negedge clk);
    pulse(1'b1);
    pulse(1'b0);
    check("R3 counts blocked", count, 4'd0);
    clrReqA = 1'b0; clrReqB = 1'b0;
    @(negedge clk);

    // R6: single preset input
    nineReqB = 1'b1;
    repeat (3) @(negedge clk);
    check("R6 nineReqB alone", count, 4'd0);
    nineReqB = 1'b0;

    // R5: preset pair, then with the clear pair also high
    @(negedge clk);
    nineReqA = 1'b1; nineReqB = 1'b1;
    #1;
    check("R5 async preset", count, 4'd9);
    clrReqA = 1'b1; clrReqB = 1'b1;
    repeat (2) @(negedge clk);
    check("R5 preset beats clear", count, 4'd9);
    nineReqA = 1'b0;
    repeat (2) @(negedge clk);
    check("R3 clear after preset drops", count, 4'd0);
    clrReqA = 1'b0; clrReqB = 1'b0;

    // R7: preset then a decimal count wraps 9 -> 0
    nineReqA = 1'b1;
    @(negedge clk);
    nineReqA = 1'b0; nineReqB = 1'b0;
    chainMode = 2'b01;
    @(negedge clk);
    pulse(1'b1);
    check("R7 wrap from preset", count, 4'd0);
    pulse(1'b1);
    check("R7 resume after wrap", count, 4'd1);

    // R10: asynchronous system reset mid-run
    rst_n = 1'b0;
    #1;
    check("R10 async reset", count, 4'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule